// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a register-programmed SPI master that moves words between a four-deep transmit queue and a four-deep receive queue. Software selects the clock polarity, the clock phase, a word length of 8 or 16 bits and a clock divider. It then loads transmit words through a data port and switches the block into its running mode. The shift engine sends each queued word MSB first, captures one word from the slave for every word it sends, and stores that word in the receive queue. A level interrupt is raised while the receive queue holds at least a programmed number of words (1 to 4), so software can collect a whole burst in one service.

The block has two operating modes. In configuration mode the control registers can be written and nothing is shifted. In running mode the control registers are frozen and the engine drains the transmit queue. A write to the mode register can also empty both queues at once, or hold the engine before it starts the next word. Chip select is driven elsewhere.

Top module: `spi_fifo_master`

## Requirements
- R1: The register offsets are mode 0x00, control-A 0x04, control-B 0x08, status 0x14 and data 0x18. After reset, mode reads 0x0040 (configuration), control-A reads 0x0000, control-B reads 0x0108, status reads 0x0004, and `irq` and `sck` are low.
- R2: Writes to control-A and control-B are ignored while the mode field (mode register bits 7:6) holds 2'b10 (running). The value 2'b01 selects configuration.
- R3: With 8-bit words, each transmit word's low 8 bits leave on `mosi` MSB first. Each word sent stores one received 8-bit word, zero-extended, in the receive queue, and the queue returns the words in order.
- R4: With 16-bit words, all 16 bits of the data-port value are sent MSB first and 16 received bits are stored.
- R5: Control-A bit 0 sets the clock polarity, which is the level of `sck` while no word is in flight. Control-A bit 1 sets the phase: with phase 0 both sides sample on the edge leaving the idle level, and with phase 1 on the edge returning to it.
- R6: Control-B bits 15:8 hold the divider n, and each bit lasts n+1 clock cycles. A written divider of 0 is stored as 1.
- R7: Control-B bits 4:0 set the word length. Only 8 and 16 are accepted, and any other value leaves the length unchanged.
- R8: Shifting starts only in running mode with a non-empty transmit queue. A data-port write to a full transmit queue is dropped and does not disturb the queued words.
- R9: A data-port read from an empty receive queue returns 0 and leaves the queue empty.
- R10: Control-A bits 13:12 hold the threshold minus one. Status bit 14 is high while the receive fill level is at or above the threshold, and `irq` equals that bit ANDed with control-A bit 9.
- R11: Writing the mode register with bit 0 set empties both queues.
- R12: While mode register bit 1 is set, the engine starts no new word. The queued words are sent once the bit is cleared.
- R13: In the status register, bits 13:11 give the transmit fill level, bits 10:8 the receive fill level, and bit 2 is high exactly when no word is in flight and the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on the data port) |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, valid in the same cycle |
| irq | output | 1 | Receive-threshold interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest conditions to reach from the ports are a receive queue standing exactly at the threshold with the enable toggled, and a full transmit queue meeting one more write. Both need the engine held back while the queues are loaded. The bench loads the transmit queue in configuration mode or with the hold bit set, and only then switches to running mode. It builds up the receive level over several short runs without clearing it in between. A behavioural slave follows `sck`, checks the bit spacing against the divider and drives `miso` from its own word list, for all four clock modes.

// File: rtl/spi_fm_pkg.sv
// Package: register offsets, mode encoding and widths shared by the SPI master.
package spi_fm_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_MODE = 5'h00;
    localparam logic [ADDR_W-1:0] A_CTLA = 5'h04;
    localparam logic [ADDR_W-1:0] A_CTLB = 5'h08;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h14;
    localparam logic [ADDR_W-1:0] A_DATA = 5'h18;

    localparam logic [4:0] LEN_BYTE = 5'd8;
    localparam logic [4:0] LEN_HALF = 5'd16;

    typedef enum logic [1:0] {
        OPM_OFF  = 2'b00,
        OPM_CFG  = 2'b01,
        OPM_RUN  = 2'b10,
        OPM_RSVD = 2'b11
    } opmode_e;
endpackage

// File: rtl/spi_fm_fifo.sv
// Module: synchronous FIFO with flush.
// Assumes: a push when full and a pop when empty are dropped; dout is 0 when empty.
module spi_fm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = empty ? '0 : mem[rp_q];
    assign count   = cnt_q;

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    // Move the pointers and the fill count; flush wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/spi_fm_engine.sv
// Module: SPI shift engine, one word at a time, MSB first.
// Assumes: div >= 1 and the configuration stays stable while busy. Each bit lasts
// div+1 cycles. miso is sampled at the mid-bit sck edge and mosi moves at bit starts.
module spi_fm_engine #(
    parameter int DIV_W  = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              len_wide,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  div,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              sck,
    output logic              mosi
);
    localparam int HALF_W = WORD_W / 2;
    localparam int BW     = $clog2(WORD_W);

    logic              busy_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [BW-1:0]     bit_q;
    logic [WORD_W-1:0] sr_q, rsr_q;
    logic [DIV_W:0]    period;
    logic [DIV_W-1:0]  mid_m1;
    logic              late_half;
    logic              bit_end;

    assign period    = {1'b0, div} + 1'b1;
    assign mid_m1    = DIV_W'((period >> 1) - 1'b1);
    assign late_half = (cnt_q > mid_m1);
    assign bit_end   = busy_q && (cnt_q == div);

    assign tx_pop  = !busy_q && go && tx_valid;
    assign rx_push = bit_end && (bit_q == '0);
    assign rx_word = len_wide ? rsr_q : {{HALF_W{1'b0}}, rsr_q[HALF_W-1:0]};
    assign busy    = busy_q;
    assign mosi    = busy_q && sr_q[WORD_W-1];
    assign sck     = busy_q ? (cpol ^ cpha ^ late_half) : cpol;

    // Load a word, step through the bit slots, sample mid-bit, shift at bit end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            sr_q   <= '0;
            rsr_q  <= '0;
        end else if (!busy_q) begin
            if (tx_pop) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                bit_q  <= len_wide ? BW'(WORD_W-1) : BW'(HALF_W-1);
                sr_q   <= len_wide ? tx_word : {tx_word[HALF_W-1:0], {HALF_W{1'b0}}};
            end
        end else begin
            if (cnt_q == mid_m1) rsr_q <= {rsr_q[WORD_W-2:0], miso};
            if (bit_end) begin
                cnt_q <= '0;
                sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
                if (bit_q == '0) busy_q <= 1'b0;
                else             bit_q  <= bit_q - 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_fifo_master.sv
// Module: top of the buffered SPI master: register decode, mode control, queues, engine.
// Assumes: single-cycle register accesses; a read strobe on the data port pops one word.
module spi_fifo_master #(
    parameter int DEPTH = 4,
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [4:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq,
    output logic        sck,
    output logic        mosi,
    input  logic        miso
);
    import spi_fm_pkg::*;

    localparam int CW = $clog2(DEPTH+1);

    opmode_e          mode_q;
    logic             hold_q;
    logic [1:0]       thr_m1_q;
    logic             rx_ie_q, cpol_q, cpha_q, len_wide_q;
    logic [DIV_W-1:0] div_q, div_in;
    logic             run_q, cfg_open, flush, go;
    logic             tx_push, tx_pop, rx_pop, rx_push, eng_busy;
    logic [15:0]      tx_din, tx_head, rx_word, rx_head;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             rx_hit;

    assign run_q    = (mode_q == OPM_RUN);
    assign cfg_open = !run_q;
    assign go       = run_q && !hold_q;
    assign flush    = wr_en && (addr == A_MODE) && wdata[0];
    assign tx_push  = wr_en && (addr == A_DATA);
    assign rx_pop   = rd_en && (addr == A_DATA);
    assign tx_din   = len_wide_q ? wdata : {8'h00, wdata[7:0]};
    assign div_in   = (wdata[8 +: DIV_W] == '0) ? DIV_W'(1) : wdata[8 +: DIV_W];
    assign rx_hit   = (rx_cnt >= (CW'(thr_m1_q) + 1'b1));
    assign irq      = rx_hit && rx_ie_q;

    // Register writes: mode always, control registers only outside running mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= OPM_CFG;
            hold_q     <= 1'b0;
            thr_m1_q   <= '0;
            rx_ie_q    <= 1'b0;
            cpol_q     <= 1'b0;
            cpha_q     <= 1'b0;
            div_q      <= DIV_W'(1);
            len_wide_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_MODE) begin
                mode_q <= opmode_e'(wdata[7:6]);
                hold_q <= wdata[1];
            end
            if (addr == A_CTLA && cfg_open) begin
                thr_m1_q <= wdata[13:12];
                rx_ie_q  <= wdata[9];
                cpha_q   <= wdata[1];
                cpol_q   <= wdata[0];
            end
            if (addr == A_CTLB && cfg_open) begin
                div_q <= div_in;
                if (wdata[4:0] == LEN_BYTE)      len_wide_q <= 1'b0;
                else if (wdata[4:0] == LEN_HALF) len_wide_q <= 1'b1;
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE: rdata = {8'h00, mode_q, 4'h0, hold_q, 1'b0};
            A_CTLA: rdata = {2'b00, thr_m1_q, 2'b00, rx_ie_q, 7'h00, cpha_q, cpol_q};
            A_CTLB: rdata = {8'(div_q), 3'b000, len_wide_q ? LEN_HALF : LEN_BYTE};
            A_STAT: rdata = {1'b0, rx_hit, 3'(tx_cnt), 3'(rx_cnt), 5'h00,
                             !eng_busy && tx_empty, 2'b00};
            A_DATA: rdata = rx_head;
            default: rdata = '0;
        endcase
    end

    spi_fm_fifo #(.W(16), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(flush), .push(tx_push), .din(tx_din),
        .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    spi_fm_fifo #(.W(16), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(flush), .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    spi_fm_engine #(.DIV_W(DIV_W), .WORD_W(16)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .tx_valid(!tx_empty), .tx_word(tx_head),
        .len_wide(len_wide_q), .cpol(cpol_q), .cpha(cpha_q), .div(div_q), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .busy(eng_busy),
        .sck(sck), .mosi(mosi));
endmodule

// File: rtl/spi_fifo_master_chk.sv
// Module: property checker for spi_fifo_master, attached by bind.
// Assumes: signals are sampled on the rising clock edge.
module spi_fifo_master_chk #(
    parameter int DEPTH = 4,
    parameter int DIV_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       run_q,
    input logic                       hold_q,
    input logic                       cpol_q,
    input logic                       cpha_q,
    input logic [DIV_W-1:0]           div_q,
    input logic                       eng_busy,
    input logic                       tx_pop,
    input logic                       rx_push,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       irq,
    input logic                       sck
);
    // R2
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> ($stable(div_q) && $stable(cpol_q) && $stable(cpha_q)));
    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (sck == cpol_q));
    // R8
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= ($clog2(DEPTH+1))'(DEPTH));
    // R8
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !eng_busy) |=> !eng_busy);
    // R12
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> !tx_pop);
    // R10
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |-> !irq);
    // R3
    push_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> eng_busy);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .hold_q(hold_q), .cpol_q(cpol_q),
    .cpha_q(cpha_q), .div_q(div_q), .eng_busy(eng_busy), .tx_pop(tx_pop),
    .rx_push(rx_push), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .irq(irq), .sck(sck));

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, wr_en, rd_en, miso;
    logic [4:0]  addr;
    logic [15:0] wdata, rdata;
    logic        irq, sck, mosi;

    spi_fifo_master dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso));

    localparam logic [4:0] MODE = 5'h00, CTLA = 5'h04, CTLB = 5'h08, STAT = 5'h14, DATA = 5'h18;

    int n_vec = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bench view of the configuration and the behavioural slave.
    bit          b_cpol = 0, b_cpha = 0, b_wide = 0, b_run = 0, b_chk = 0;
    int          b_div = 1;
    logic [15:0] s_q[$];
    logic [15:0] got_q[$];
    logic [15:0] s_cur = 16'h0, mrx = 16'h0;
    int          k = 0, last_cyc = 0, edges = 0;
    logic        prev_sck = 1'b0;

    assign miso = s_cur[(b_wide ? 15 : 7) - k];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-clock slave: follows sck edges, checks bit spacing, collects mosi words.
    always @(negedge clk) begin
        if (b_run) begin
            bit lead, trail, samp;
            lead  = (prev_sck == b_cpol) && (sck != b_cpol);
            trail = (prev_sck != b_cpol) && (sck == b_cpol);
            if (lead || trail) edges++;
            samp = b_cpha ? trail : lead;
            if (samp) begin
                if (k > 0) chk("R6 bit spacing", cyc - last_cyc, b_div + 1);
                last_cyc = cyc;
                mrx = {mrx[14:0], mosi};
                k++;
                if (k == (b_wide ? 16 : 8)) begin
                    got_q.push_back(b_wide ? mrx : {8'h00, mrx[7:0]});
                    k = 0;
                    s_cur = (s_q.size() > 0) ? s_q.pop_front() : 16'h0;
                end
            end
        end else if (b_chk) begin
            chk("R5 idle sck level", sck, b_cpol);
        end
        prev_sck = sck;
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] st;
        for (int i = 0; i < 3000; i++) begin
            rd(STAT, st);
            if (st[2]) break;
        end
    endtask

    task automatic load_slave(input int n, input logic [15:0] sl [4]);
        s_q.delete(); got_q.delete();
        for (int i = 1; i < n; i++) s_q.push_back(sl[i]);
        s_cur = sl[0]; k = 0;
    endtask

    task automatic run_now();
        b_run = 1; edges = 0;
        wr(MODE, 16'h0080);
        wait_idle();
        repeat (2) @(negedge clk);
        b_run = 0;
    endtask

    task automatic burst(input bit pol, input bit pha, input bit wide, input int dv,
                         input logic [15:0] ctla_x, input int n,
                         input logic [15:0] tx [4], input logic [15:0] sl [4],
                         input bit clear_first, input bit read_rx, input string tag);
        logic [15:0] v;
        b_chk = 0;
        wr(MODE, clear_first ? 16'h0041 : 16'h0040);
        wr(CTLA, ctla_x | {14'h0, pha, pol});
        wr(CTLB, {dv[7:0], 3'b000, wide ? 5'd16 : 5'd8});
        b_cpol = pol; b_cpha = pha; b_wide = wide; b_div = dv;
        for (int i = 0; i < n; i++) wr(DATA, tx[i]);
        load_slave(n, sl);
        repeat (2) @(negedge clk);
        b_chk = 1;
        repeat (3) @(negedge clk);
        run_now();
        chk({tag, " word count"}, got_q.size(), n);
        for (int i = 0; i < n && i < got_q.size(); i++)
            chk({tag, " mosi word"}, got_q[i], wide ? tx[i] : {8'h00, tx[i][7:0]});
        if (read_rx) begin
            rd(STAT, v);
            chk({tag, " rx level (R13)"}, v[10:8], n);
            for (int i = 0; i < n; i++) begin
                rd(DATA, v);
                chk({tag, " miso word"}, v, wide ? sl[i] : {8'h00, sl[i][7:0]});
            end
        end
        b_chk = 0;
        wr(MODE, 16'h0040);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] ta [4], sa [4];
        rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq, 1'b0);
        chk("R1 sck", sck, 1'b0);
        rd(MODE, v); chk("R1 mode reg", v, 16'h0040);
        rd(CTLA, v); chk("R1 ctla reg", v, 16'h0000);
        rd(CTLB, v); chk("R1 ctlb reg", v, 16'h0108);
        rd(STAT, v); chk("R1 status reg", v, 16'h0004);

        // R6 divider clamp, R7 illegal length ignored
        wr(CTLB, 16'h0010); rd(CTLB, v); chk("R6 zero divider", v, 16'h0110);
        wr(CTLB, 16'h0305); rd(CTLB, v); chk("R7 bad length", v, 16'h0310);
        wr(CTLB, 16'h0108);

        // R9 empty pop
        rd(DATA, v); chk("R9 empty pop", v, 16'h0000);
        rd(STAT, v); chk("R9 level after pop", v[10:8], 0);

        // R3 8-bit, mode 0, fastest divider
        ta = '{16'h12A5, 16'h003C, 16'hFF81, 16'h0F0F};
        sa = '{16'h005A, 16'h00C3, 16'h0001, 16'h00FE};
        burst(0, 0, 0, 1, 16'h0, 4, ta, sa, 1, 1, "R3");

        // R4 16-bit words
        ta = '{16'hBEEF, 16'h8001, 16'h1234, 16'h0};
        sa = '{16'hCAFE, 16'h7FFE, 16'hA5A5, 16'h0};
        burst(0, 0, 1, 3, 16'h0, 3, ta, sa, 1, 1, "R4");

        // R5 other clock modes
        ta = '{16'h00B4, 16'h0067, 16'h0, 16'h0};
        sa = '{16'h0039, 16'h00D2, 16'h0, 16'h0};
        burst(1, 0, 0, 2, 16'h0, 2, ta, sa, 1, 1, "R5 pol1 pha0");
        burst(0, 1, 0, 6, 16'h0, 2, ta, sa, 1, 1, "R5 pol0 pha1");
        ta = '{16'h9C3E, 16'h0, 16'h0, 16'h0};
        sa = '{16'h61C7, 16'h0, 16'h0, 16'h0};
        burst(1, 1, 1, 4, 16'h0, 1, ta, sa, 1, 1, "R5 pol1 pha1");
        chk("R5 edge count", edges, 32);

        // R2 writes ignored in running mode
        wr(MODE, 16'h0080);
        wr(CTLB, 16'h0508); wr(CTLA, 16'h3203);
        rd(CTLB, v); chk("R2 ctlb frozen", v, 16'h0410);
        rd(CTLA, v); chk("R2 ctla frozen", v, 16'h0003);
        wr(MODE, 16'h0040);

        // R8 full push dropped, nothing shifts in configuration mode
        wr(MODE, 16'h0041);
        wr(CTLA, 16'h0000); wr(CTLB, 16'h0108);
        b_cpol = 0; b_cpha = 0; b_wide = 0; b_div = 1;
        for (int i = 0; i < 5; i++) wr(DATA, 16'(16'h11 * (i + 1)));
        repeat (20) @(negedge clk);
        rd(STAT, v);
        chk("R8 tx level full", v[13:11], 4);
        chk("R8 no shift in config", v[2], 1'b0);
        sa = '{16'h1, 16'h2, 16'h3, 16'h4};
        load_slave(4, sa);
        run_now();
        chk("R8 words sent", got_q.size(), 4);
        for (int i = 0; i < 4 && i < got_q.size(); i++)
            chk("R8 queue order", got_q[i], 16'(16'h11 * (i + 1)));

        // R11 flush both queues
        rd(STAT, v); chk("R11 rx before flush", v[10:8], 4);
        wr(MODE, 16'h0040);
        wr(DATA, 16'h0077);
        wr(MODE, 16'h0041);
        rd(STAT, v); chk("R11 status after flush", v, 16'h0004);
        rd(DATA, v); chk("R11 R9 pop after flush", v, 16'h0000);

        // R10 threshold 3, built up over two runs
        ta = '{16'h21, 16'h43, 16'h0, 16'h0};
        sa = '{16'h0A, 16'h0B, 16'h0, 16'h0};
        burst(0, 0, 0, 1, 16'h2200, 2, ta, sa, 1, 0, "R10 first run");
        rd(STAT, v); chk("R10 below threshold bit", v[14], 1'b0);
        chk("R10 below threshold irq", irq, 1'b0);
        ta = '{16'h65, 16'h0, 16'h0, 16'h0};
        sa = '{16'h0C, 16'h0, 16'h0, 16'h0};
        burst(0, 0, 0, 1, 16'h2200, 1, ta, sa, 0, 0, "R10 second run");
        rd(STAT, v); chk("R10 at threshold bit", v[14], 1'b1);
        chk("R10 at threshold irq", irq, 1'b1);
        wr(CTLA, 16'h2000);
        @(negedge clk); chk("R10 irq masked", irq, 1'b0);
        wr(CTLA, 16'h2200);
        @(negedge clk); chk("R10 irq unmasked", irq, 1'b1);
        rd(DATA, v); chk("R10 first rx word", v, 16'h000A);
        @(negedge clk); chk("R10 irq after pop", irq, 1'b0);
        rd(STAT, v); chk("R10 bit after pop", v[14], 1'b0);

        // R12 hold, R13 idle bit
        wr(MODE, 16'h0041);
        wr(CTLA, 16'h0000);
        b_cpol = 0;
        wr(DATA, 16'h00C1); wr(DATA, 16'h00D2);
        sa = '{16'h0E, 16'h0F, 16'h0, 16'h0};
        load_slave(2, sa);
        b_run = 1; edges = 0;
        wr(MODE, 16'h0082);
        repeat (40) @(negedge clk);
        chk("R12 no edges while held", edges, 0);
        rd(STAT, v);
        chk("R12 tx kept while held", v[13:11], 2);
        chk("R13 idle low with pending words", v[2], 1'b0);
        wr(MODE, 16'h0080);
        wait_idle();
        repeat (2) @(negedge clk);
        b_run = 0;
        chk("R12 words after release", got_q.size(), 2);
        rd(STAT, v);
        chk("R13 idle high when drained", v[2], 1'b1);
        chk("R13 tx level drained", v[13:11], 0);
        chk("R13 rx level", v[10:8], 2);

        summary();
        $finish;
    end
endmodule